// File: doc/BRIEF.md
# Calendar Counter with Masked Alarm

This block keeps wall-clock time for a real-time clock. It holds the current date and time as separate fields (seconds, minutes, hours, day of month, day of week, month and a 7-bit year count after 2000) and advances them by one second on each pulse of a once-per-second tick input. Carries ripple from seconds up to the year. The length of each month is taken into account, and February has 29 days in every year whose count is a multiple of 4.

A second set of fields holds an alarm time. A mask register takes chosen fields out of the comparison. When every field that is still compared matches the running time on a tick, the alarm event is raised. A tick event is raised on every second. Each event sets a pending bit only if its enable bit is set. Pending bits are cleared by reading them, and they drive an active-low, level-sensitive interrupt. A one-shot enable lets the alarm disarm itself after it fires once.

A commit block upstream delivers single-register writes, each already qualified, on a write strobe. Reads return live values with no wait state.

Top module: `rtc_calendar_core`

## Requirements
- R1: After synchronous reset the time reads 00:00:00 on day 1 of month 1 of year 0, with day of week 0. All alarm fields read 0. The mask, enable and pending registers read 0, and irq_n is high.
- R2: Each tick with no write adds one second. Seconds run 0..59 and carry into minutes. Minutes run 0..59 and carry into hours. Hours run 0..23 and carry into the day. With no tick and no write, the time holds.
- R3: When the day carries, day of month goes from the last day of the month back to 1. The last day is 30 for months 4, 6, 9 and 11. For month 2 it is 29 if year mod 4 is 0 and 28 otherwise. For all other months it is 31. Day of week advances with every day carry and wraps from 6 to 0.
- R4: When day 31 of month 12 carries, the month becomes 1 and the year advances by 1. Year 127 wraps to 0.
- R5: The time fields are at byte offsets 0x14, 0x18, 0x1C, 0x20, 0x24, 0x28 and 0x2C, for seconds, minutes, hours, day of month, day of week, month and year. Their widths are 6, 6, 5, 5, 3, 4 and 7 bits. A write stores only the low bits of the data, up to the field width. If a write arrives in the same cycle as a tick, the written field takes the written value and the other fields still advance.
- R6: The alarm fields use the same order and widths at offsets 0x30 through 0x48 in steps of 4. The mask register at 0x10 holds bits 0..6 for seconds, minutes, hours, day of month, day of week, month and year. A set bit removes that field from the comparison. The alarm event occurs on a tick after which every field that is not masked equals its alarm value.
- R7: The pending register is at 0x04, with bit 0 for alarm and bit 1 for tick. The enable register is at 0x08, with bit 0 for alarm, bit 1 for tick and bit 2 for one-shot. An event sets its pending bit only if it is enabled, and it does so one cycle after the tick that updated the time. A read of 0x04 returns the pending bits and then clears them.
- R8: irq_n is low while any pending bit is set and high otherwise.
- R9: When the alarm fires while enable bit 2 is set, enable bit 0 clears in the same cycle. A later match then sets no pending bit.
- R10: Reads of the time, alarm, mask and enable registers return their live values. Any other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| wr_en | input | 1 | Committed register write strobe |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe (clears pending on 0x04) |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 16 | Live read data |
| irq_n | output | 1 | Active-low interrupt level |

## Verification
The bench goes after the points where carries meet month lengths. It places the time one second before the end of the month in every month of five consecutive years, so each leap-year February is reached. A design that used a fixed 31-day month, or tested the wrong year bits, would show day 29, 30 or 31 where day 1 of the next month is expected. It also steps across the end of year 127, where a missing wrap or a stale day of week shows at once. It issues a write in the same cycle as a tick, and a design that let the tick overwrite the write, or that froze the whole counter, gives the wrong minute or second. For the alarm, it checks that day of week is ignored only when masked, that the alarm fires once and not on the next tick, that a read clears pending and releases irq_n, and that one-shot disarms the alarm enable.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 16;
    localparam int NFIELD     = 7;
    localparam int FIELD_MAXW = 7;
    localparam int IDX_W      = $clog2(NFIELD);

    localparam int SEC_W  = 6;
    localparam int MIN_W  = 6;
    localparam int HOUR_W = 5;
    localparam int MDAY_W = 5;
    localparam int WDAY_W = 3;
    localparam int MON_W  = 4;
    localparam int YEAR_W = 7;

    localparam int EN_W   = 3;
    localparam int PEND_W = 2;

    localparam logic [ADDR_W-1:0] OFS_PEND = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_IEN  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_MASK = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_TIME = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_ALRM = 8'h30;

    typedef logic [FIELD_MAXW-1:0] fval_t;
    typedef logic [IDX_W-1:0]      fidx_t;

    typedef struct packed {
        logic [YEAR_W-1:0] year;
        logic [MON_W-1:0]  mon;
        logic [WDAY_W-1:0] wday;
        logic [MDAY_W-1:0] mday;
        logic [HOUR_W-1:0] hour;
        logic [MIN_W-1:0]  mins;
        logic [SEC_W-1:0]  sec;
    } cal_t;

    typedef struct packed {
        logic  hit;
        fidx_t idx;
    } fsel_t;

    localparam cal_t CAL_RESET = '{year: '0, mon: MON_W'(1), wday: '0,
                                   mday: MDAY_W'(1), hour: '0, mins: '0, sec: '0};

    function automatic fval_t cal_get(cal_t c, fidx_t i);
        fval_t v;
        v = '0;
        case (i)
            3'd0: v = fval_t'(c.sec);
            3'd1: v = fval_t'(c.mins);
            3'd2: v = fval_t'(c.hour);
            3'd3: v = fval_t'(c.mday);
            3'd4: v = fval_t'(c.wday);
            3'd5: v = fval_t'(c.mon);
            3'd6: v = c.year;
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic cal_t cal_put(cal_t c, fidx_t i, fval_t v);
        cal_t r;
        r = c;
        case (i)
            3'd0: r.sec  = v[SEC_W-1:0];
            3'd1: r.mins = v[MIN_W-1:0];
            3'd2: r.hour = v[HOUR_W-1:0];
            3'd3: r.mday = v[MDAY_W-1:0];
            3'd4: r.wday = v[WDAY_W-1:0];
            3'd5: r.mon  = v[MON_W-1:0];
            3'd6: r.year = v[YEAR_W-1:0];
            default: r = c;
        endcase
        return r;
    endfunction

    function automatic logic [MDAY_W-1:0] month_days(logic [MON_W-1:0] m,
                                                      logic [YEAR_W-1:0] y);
        logic [MDAY_W-1:0] d;
        case (m)
            4'd2:                   d = (y[1:0] == 2'b00) ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11: d = 5'd30;
            default:                d = 5'd31;
        endcase
        return d;
    endfunction

    function automatic fsel_t field_sel(logic [ADDR_W-1:0] a, logic [ADDR_W-1:0] base);
        fsel_t s;
        logic [ADDR_W-1:0] off;
        off   = a - base;
        s.hit = (a >= base) && (off[1:0] == 2'b00) && ((off >> 2) < ADDR_W'(NFIELD));
        s.idx = off[IDX_W+1:2];
        return s;
    endfunction

endpackage

// File: rtl/rtc_cal_counter.sv
module rtc_cal_counter
    import rtc_cal_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  wr_en,
    input  fidx_t wr_idx,
    input  fval_t wr_val,
    output cal_t  now
);

    cal_t step, nxt;
    logic [MDAY_W-1:0] dim;
    logic c_sec, c_min, c_hr, c_day, c_mon;

    always_comb begin
        dim   = month_days(now.mon, now.year);
        c_sec = now.sec  >= SEC_W'(59);
        c_min = c_sec && (now.mins >= MIN_W'(59));
        c_hr  = c_min && (now.hour >= HOUR_W'(23));
        c_day = c_hr  && (now.mday >= dim);
        c_mon = c_day && (now.mon  >= MON_W'(12));

        step     = now;
        step.sec = c_sec ? '0 : now.sec + SEC_W'(1);
        if (c_sec) step.mins = c_min ? '0 : now.mins + MIN_W'(1);
        if (c_min) step.hour = c_hr  ? '0 : now.hour + HOUR_W'(1);
        if (c_hr) begin
            step.mday = c_day ? MDAY_W'(1) : now.mday + MDAY_W'(1);
            step.wday = (now.wday >= WDAY_W'(6)) ? '0 : now.wday + WDAY_W'(1);
        end
        if (c_day) step.mon  = c_mon ? MON_W'(1) : now.mon + MON_W'(1);
        if (c_mon) step.year = now.year + YEAR_W'(1);

        nxt = tick ? step : now;
        if (wr_en) nxt = cal_put(nxt, wr_idx, wr_val);
    end

    always_ff @(posedge clk) begin
        if (rst) now <= CAL_RESET;
        else     now <= nxt;
    end

    AST_SEC_STEP: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_en && now.sec < SEC_W'(59)) |=> (now.sec == $past(now.sec) + SEC_W'(1))); // R2
    AST_TIME_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!tick && !wr_en) |=> $stable(now)); // R2
    AST_MDAY_WRAP: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_en && now.sec == SEC_W'(59) && now.mins == MIN_W'(59) &&
         now.hour == HOUR_W'(23) && now.mday == month_days(now.mon, now.year))
        |=> (now.mday == MDAY_W'(1))); // R3

endmodule

// File: rtl/rtc_cal_alarm.sv
module rtc_cal_alarm
    import rtc_cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  fidx_t             wr_idx,
    input  fval_t             wr_val,
    input  logic              mask_we,
    input  logic [NFIELD-1:0] mask_val,
    input  cal_t              now,
    output cal_t              alarm,
    output logic [NFIELD-1:0] mask,
    output logic              match
);

    logic [NFIELD-1:0] ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            alarm <= '0;
            mask  <= '0;
        end else begin
            if (wr_en)   alarm <= cal_put(alarm, wr_idx, wr_val);
            if (mask_we) mask  <= mask_val;
        end
    end

    for (genvar g = 0; g < NFIELD; g++) begin : g_cmp
        assign ok[g] = mask[g] || (cal_get(now, fidx_t'(g)) == cal_get(alarm, fidx_t'(g)));
    end

    assign match = &ok;

    AST_WDAY_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (mask[4] && now.sec == alarm.sec && now.mins == alarm.mins && now.hour == alarm.hour &&
         now.mday == alarm.mday && now.mon == alarm.mon && now.year == alarm.year) |-> match); // R6

endmodule

// File: rtl/rtc_cal_irq.sv
module rtc_cal_irq
    import rtc_cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              match,
    input  logic              en_we,
    input  logic [EN_W-1:0]   en_val,
    input  logic              rd_clr,
    output logic [PEND_W-1:0] pend,
    output logic [EN_W-1:0]   ien,
    output logic              irq_n
);

    logic tick_q;
    logic fire_al, fire_tk;

    assign fire_al = tick_q && match && ien[0];
    assign fire_tk = tick_q && ien[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q <= 1'b0;
            pend   <= '0;
            ien    <= '0;
        end else begin
            tick_q <= tick;
            pend   <= (rd_clr ? '0 : pend) | {fire_tk, fire_al};
            if (en_we)                 ien    <= en_val;
            else if (fire_al && ien[2]) ien[0] <= 1'b0;
        end
    end

    assign irq_n = ~|pend;

    AST_ONESHOT_DROP: assert property (@(posedge clk) disable iff (rst)
        (tick_q && match && ien[0] && ien[2] && !en_we) |=> !ien[0]); // R9
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && !tick_q) |=> (pend == '0)); // R7
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !tick_q |=> ((pend & ~$past(pend)) == '0)); // R7

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1hz,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_n
);

    fsel_t wt, wa, rt, ra;
    cal_t  now, alarm;
    logic [NFIELD-1:0] mask;
    logic [PEND_W-1:0] pend;
    logic [EN_W-1:0]   ien;
    logic match, rd_clr, mask_we, en_we;
    fval_t wr_val;

    assign wt      = field_sel(wr_addr, OFS_TIME);
    assign wa      = field_sel(wr_addr, OFS_ALRM);
    assign rt      = field_sel(rd_addr, OFS_TIME);
    assign ra      = field_sel(rd_addr, OFS_ALRM);
    assign wr_val  = wr_data[FIELD_MAXW-1:0];
    assign mask_we = wr_en && (wr_addr == OFS_MASK);
    assign en_we   = wr_en && (wr_addr == OFS_IEN);
    assign rd_clr  = rd_en && (rd_addr == OFS_PEND);

    rtc_cal_counter u_cnt (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick_1hz),
        .wr_en  (wr_en && wt.hit),
        .wr_idx (wt.idx),
        .wr_val (wr_val),
        .now    (now)
    );

    rtc_cal_alarm u_alm (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en && wa.hit),
        .wr_idx   (wa.idx),
        .wr_val   (wr_val),
        .mask_we  (mask_we),
        .mask_val (wr_data[NFIELD-1:0]),
        .now      (now),
        .alarm    (alarm),
        .mask     (mask),
        .match    (match)
    );

    rtc_cal_irq u_irq (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick_1hz),
        .match  (match),
        .en_we  (en_we),
        .en_val (wr_data[EN_W-1:0]),
        .rd_clr (rd_clr),
        .pend   (pend),
        .ien    (ien),
        .irq_n  (irq_n)
    );

    always_comb begin
        rd_data = '0;
        if (rt.hit)                    rd_data = DATA_W'(cal_get(now, rt.idx));
        else if (ra.hit)               rd_data = DATA_W'(cal_get(alarm, ra.idx));
        else if (rd_addr == OFS_MASK)  rd_data = DATA_W'(mask);
        else if (rd_addr == OFS_IEN)   rd_data = DATA_W'(ien);
        else if (rd_addr == OFS_PEND)  rd_data = DATA_W'(pend);
    end

endmodule

// File: tb/rtc_calendar_core_tb.sv
module rtc_calendar_core_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_1hz = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        irq_n;

    int n_run = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rtc_calendar_core u_dut (
        .clk(clk), .rst(rst), .tick_1hz(tick_1hz),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq_n(irq_n)
    );

    localparam logic [7:0] A_SEC = 8'h14, A_MIN = 8'h18, A_HR = 8'h1C, A_MD = 8'h20,
                           A_WD = 8'h24, A_MON = 8'h28, A_YR = 8'h2C;

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d[15:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output int d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        #1 d = int'(rd_data);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic tick1();
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_time(input int y, input int mo, input int d, input int w,
                            input int h, input int mi, input int s);
        wr(A_YR, y); wr(A_MON, mo); wr(A_MD, d); wr(A_WD, w);
        wr(A_HR, h); wr(A_MIN, mi); wr(A_SEC, s);
    endtask

    task automatic rdchk(input string tag, input logic [7:0] a, input int exp);
        int v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    function automatic int dim_of(input int mo, input int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++; n_run++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        chk("R1 irq_n", int'(irq_n), 1);
        rdchk("R1 sec", A_SEC, 0);
        rdchk("R1 mday", A_MD, 1);
        rdchk("R1 mon", A_MON, 1);
        rdchk("R1 year", A_YR, 0);
        rdchk("R1 wday", A_WD, 0);
        rdchk("R1 alarm sec", 8'h30, 0);
        rdchk("R1 mask", 8'h10, 0);
        rdchk("R1 enable", 8'h08, 0);
        rdchk("R1 pending", 8'h04, 0);

        // R2 two-minute sweep across midnight
        set_time(10, 6, 15, 2, 23, 58, 0);
        for (int k = 1; k <= 120; k++) begin
            int t;
            t = 23 * 3600 + 58 * 60 + k;
            tick1();
            rdchk("R2 sec", A_SEC, t % 60);
            rdchk("R2 min", A_MIN, (t / 60) % 60);
            rdchk("R2 hour", A_HR, (t / 3600) % 24);
            rdchk("R3 mday", A_MD, 15 + t / 86400);
        end
        // R2 hold without tick
        repeat (5) @(negedge clk);
        rdchk("R2 hold sec", A_SEC, 0);

        // R3 R4 month ends over five years
        for (int y = 0; y < 5; y++) begin
            for (int mo = 1; mo <= 12; mo++) begin
                int dm;
                dm = dim_of(mo, y);
                set_time(y, mo, dm - 1, 3, 23, 59, 59);
                tick1();
                rdchk("R3 last day", A_MD, dm);
                rdchk("R3 wday step", A_WD, 4);
                wr(A_HR, 23); wr(A_MIN, 59); wr(A_SEC, 59);
                tick1();
                rdchk("R3 first day", A_MD, 1);
                rdchk("R4 month", A_MON, (mo == 12) ? 1 : mo + 1);
                rdchk("R4 year", A_YR, (mo == 12) ? y + 1 : y);
            end
        end

        // R4 year 127 wrap, R3 weekday wrap
        set_time(127, 12, 31, 6, 23, 59, 59);
        tick1();
        rdchk("R4 year wrap", A_YR, 0);
        rdchk("R4 month wrap", A_MON, 1);
        rdchk("R4 mday wrap", A_MD, 1);
        rdchk("R3 wday wrap", A_WD, 0);

        // R5 width truncation
        wr(A_SEC, 16'hFFFF);
        rdchk("R5 sec width", A_SEC, 63);
        wr(A_WD, 16'h00FF);
        rdchk("R5 wday width", A_WD, 7);

        // R5 write concurrent with tick
        set_time(20, 3, 10, 2, 10, 20, 59);
        @(negedge clk);
        tick_1hz = 1'b1; wr_en = 1'b1; wr_addr = A_MIN; wr_data = 16'd5;
        @(negedge clk);
        tick_1hz = 1'b0; wr_en = 1'b0;
        rdchk("R5 written min", A_MIN, 5);
        rdchk("R5 sec advanced", A_SEC, 0);
        rdchk("R5 hour kept", A_HR, 10);

        // R6 alarm with weekday masked
        set_time(20, 3, 10, 2, 10, 20, 0);
        wr(8'h30, 3); wr(8'h34, 20); wr(8'h38, 10); wr(8'h3C, 10);
        wr(8'h40, 5); wr(8'h44, 3); wr(8'h48, 20);
        wr(8'h10, 16'h0010);
        wr(8'h08, 1);
        rdchk("R10 alarm min", 8'h34, 20);
        rdchk("R10 mask", 8'h10, 16);
        rdchk("R10 unmapped", 8'h0C, 0);
        tick1();
        rdchk("R6 no match s1", 8'h04, 0);
        tick1();
        rdchk("R6 no match s2", 8'h04, 0);
        tick1();
        chk("R8 irq low", int'(irq_n), 0);
        rdchk("R6 match s3", 8'h04, 1);
        chk("R8 irq released", int'(irq_n), 1);
        rdchk("R7 cleared", 8'h04, 0);
        tick1();
        rdchk("R6 once", 8'h04, 0);
        chk("R8 irq high", int'(irq_n), 1);

        // R6 weekday compared when unmasked
        wr(8'h10, 0);
        wr(A_SEC, 2);
        tick1();
        rdchk("R6 wday mismatch", 8'h04, 0);
        chk("R6 irq high", int'(irq_n), 1);

        // R9 one-shot
        wr(8'h10, 16'h0010);
        wr(8'h08, 5);
        wr(A_SEC, 2);
        tick1();
        chk("R9 irq low", int'(irq_n), 0);
        rdchk("R9 enable after fire", 8'h08, 4);
        rdchk("R9 pending", 8'h04, 1);
        wr(A_SEC, 2);
        tick1();
        rdchk("R9 disarmed", 8'h04, 0);

        // R7 tick event
        wr(8'h08, 2);
        tick1();
        chk("R8 tick irq", int'(irq_n), 0);
        rdchk("R7 tick pending", 8'h04, 2);
        rdchk("R7 tick cleared", 8'h04, 0);
        wr(8'h08, 0);
        tick1();
        rdchk("R7 disabled tick", 8'h04, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

endmodule